// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one 32-bit timer channel. Its count clock comes from one of three sources: the bus clock, the bus clock divided by sixteen, or rising edges of an external input pin that is first synchronized to the bus clock. The chosen source feeds a divider that can be set from 1 to 256, and each output tick of the divider advances the counter by one. When a chosen transition of the synchronized pin occurs, the current count is latched into a capture register. When the counter matches a reference value, the channel flags the match. It can then return the count to zero and drive an output pin.

Each event sets a flag that stays set until it is cleared. Software clears a flag by writing a one to it, and a DMA acknowledge also clears the flags. A per-channel routing bit sends the pending event either to an interrupt line or to a DMA request line, and never to both. Software controls the channel through a small local register map. Registers are written in one cycle, and a read returns data in the same cycle it is addressed.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, every register reads zero, the output pin is high, and both request lines are low. The register offsets are: 0 control, 1 reference, 2 capture (read only), 3 counter, 4 event flags. Offsets 5 to 7 read zero.
- R2: Reading the counter never changes the count. A write to offset 3 clears the counter to zero whatever the write data, and this clear takes priority over a count tick in the same cycle.
- R3: Control register layout: bit 0 enable, bits 2:1 clock source, bit 3 restart on match, bit 4 reference-request enable, bit 5 output toggle mode, bits 7:6 capture edge, bits 15:8 divider value, bit 16 DMA routing. The clock source field is decoded as follows: 00 means no source and the counter stays still; 01 selects the bus clock; 10 selects the bus clock divided by 16; 11 selects each rising edge of the synchronized input pin.
- R4: The divider passes one tick to the counter for every (divider value + 1) source ticks. The divider is held at zero while the channel is disabled, so the first count comes one full divided period after enabling. A disabled counter holds its value.
- R5: The input pin passes through a two-stage synchronizer. A capture then samples the count that is held just before the clock edge two cycles after the edge at which the pin change is first sampled.
- R6: The capture edge field is decoded as follows: 00 means no capture; 01 selects rising edges; 10 selects falling edges; 11 selects both. A selected edge, while the channel is enabled, latches the counter into the capture register and sets event bit 0. Edges that are not selected are ignored.
- R7: A count tick that finds the counter equal to the reference sets event bit 1. With restart set, the counter goes to zero on that tick. Otherwise it keeps incrementing.
- R8: With toggle mode clear, a match drives the output pin low until the next count tick.
- R9: With toggle mode set, each match inverts the output pin.
- R10: The pending request is event bit 0, or event bit 1 when reference-request enable is set. It appears on the interrupt line when DMA routing is 0 and on the DMA request line when DMA routing is 1. The two lines are never high together.
- R11: Event flags stay set until cleared. Writing a one to a bit at offset 4 clears that flag only. A DMA acknowledge pulse clears both flags.
- R12: A capture and a reference match that fall in the same cycle are both recorded. The capture holds the reference value, and both flags are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the addressed offset |
| dma_ack | input | 1 | DMA acknowledge, clears both event flags |
| tmr_in | input | 1 | Asynchronous timer input pin |
| tmr_out | output | 1 | Timer output pin, idles high |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The capture path and the reference compare path can act on the same clock edge. One check provokes this on purpose: the pin edge is driven so that, after the synchronizer delay, the selected edge lands on the tick that matches the reference with restart enabled. The check then requires three results together: both event flags set, the captured value equal to the reference, and the counter back at zero. A second coincidence is a counter write on the same edge as a tick, where the clear has to win.

// File: rtl/ctm_pkg.sv
`timescale 1ns/1ps
package ctm_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;
    localparam int PSC_W  = 8;
    localparam int DIV_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 3'd0,
        ADDR_REF  = 3'd1,
        ADDR_CAP  = 3'd2,
        ADDR_CNT  = 3'd3,
        ADDR_EVT  = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_BUS   = 2'd1,
        SRC_BUS16 = 2'd2,
        SRC_PIN   = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } cap_edge_e;

    typedef struct packed {
        logic             dma_route;
        logic [PSC_W-1:0] divider;
        cap_edge_e        cap_edge;
        logic             toggle;
        logic             ref_req;
        logic             restart;
        clk_src_e         src;
        logic             enable;
    } ctrl_t;

    localparam int CTRL_W  = $bits(ctrl_t);
    localparam int EVT_CAP = 0;
    localparam int EVT_REF = 1;

    function automatic logic edge_selected(cap_edge_e sel, logic rise, logic fall);
        case (sel)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_BOTH: return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ctm_input_sync.sv
`timescale 1ns/1ps
module ctm_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], pin};
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/ctm_prescaler.sv
`timescale 1ns/1ps
module ctm_prescaler
    import ctm_pkg::*;
#(
    parameter int P_W = PSC_W,
    parameter int D_W = DIV_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           enable,
    input  clk_src_e       src,
    input  logic [P_W-1:0] divider,
    input  logic           pin_rise,
    output logic           tick
);
    logic [D_W-1:0] fixed_q;
    logic [P_W-1:0] div_q;
    logic           src_tick;
    logic           wrap;

    always_ff @(posedge clk) begin
        if (rst || !enable) fixed_q <= '0;
        else                fixed_q <= fixed_q + 1'b1;
    end

    always_comb begin
        case (src)
            SRC_BUS:   src_tick = enable;
            SRC_BUS16: src_tick = enable && (fixed_q == {D_W{1'b1}});
            SRC_PIN:   src_tick = enable && pin_rise;
            default:   src_tick = 1'b0;
        endcase
    end

    assign wrap = (div_q >= divider);
    assign tick = src_tick && wrap;

    always_ff @(posedge clk) begin
        if (rst || !enable) div_q <= '0;
        else if (src_tick)  div_q <= wrap ? '0 : div_q + 1'b1;
    end
endmodule

// File: rtl/ctm_count_core.sv
`timescale 1ns/1ps
module ctm_count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear,
    input  logic             restart,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             cap_strobe,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capture,
    output logic             match
);
    assign match = tick && !clear && (count == ref_val);

    always_ff @(posedge clk) begin
        if (rst || clear)          count <= '0;
        else if (match && restart) count <= '0;
        else if (tick)             count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)             capture <= '0;
        else if (cap_strobe) capture <= count;
    end
endmodule

// File: rtl/ctm_out_drive.sv
`timescale 1ns/1ps
module ctm_out_drive (
    input  logic clk,
    input  logic rst,
    input  logic match,
    input  logic tick,
    input  logic toggle,
    output logic pin
);
    always_ff @(posedge clk) begin
        if (rst)                  pin <= 1'b1;
        else if (toggle) begin
            if (match)            pin <= ~pin;
        end
        else if (match)           pin <= 1'b0;
        else if (tick)            pin <= 1'b1;
    end
endmodule

// File: rtl/capcmp_timer.sv
`timescale 1ns/1ps
module capcmp_timer
    import ctm_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              dma_ack,
    input  logic              tmr_in,
    output logic              tmr_out,
    output logic              irq,
    output logic              dma_req
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] capture;
    logic             pin_rise, pin_fall;
    logic             tick, match, cap_hit;
    logic             cap_flag, ref_flag;
    logic             wr_ctrl, wr_ref, wr_cnt, wr_evt;
    logic             pending;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_ref  = reg_wr && (reg_addr == ADDR_REF);
    assign wr_cnt  = reg_wr && (reg_addr == ADDR_CNT);
    assign wr_evt  = reg_wr && (reg_addr == ADDR_EVT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ref_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (wr_ref)  ref_q  <= reg_wdata[CNT_W-1:0];
        end
    end

    ctm_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (tmr_in),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    ctm_prescaler u_psc (
        .clk      (clk),
        .rst      (rst),
        .enable   (ctrl_q.enable),
        .src      (ctrl_q.src),
        .divider  (ctrl_q.divider),
        .pin_rise (pin_rise),
        .tick     (tick)
    );

    assign cap_hit = ctrl_q.enable && edge_selected(ctrl_q.cap_edge, pin_rise, pin_fall);

    ctm_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .clear      (wr_cnt),
        .restart    (ctrl_q.restart),
        .ref_val    (ref_q),
        .cap_strobe (cap_hit),
        .count      (count),
        .capture    (capture),
        .match      (match)
    );

    ctm_out_drive u_out (
        .clk    (clk),
        .rst    (rst),
        .match  (match),
        .tick   (tick),
        .toggle (ctrl_q.toggle),
        .pin    (tmr_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_flag <= 1'b0;
            ref_flag <= 1'b0;
        end else begin
            if (cap_hit)                                     cap_flag <= 1'b1;
            else if (dma_ack || (wr_evt && reg_wdata[EVT_CAP])) cap_flag <= 1'b0;
            if (match)                                       ref_flag <= 1'b1;
            else if (dma_ack || (wr_evt && reg_wdata[EVT_REF])) ref_flag <= 1'b0;
        end
    end

    assign pending = cap_flag | (ref_flag & ctrl_q.ref_req);
    assign irq     = pending & ~ctrl_q.dma_route;
    assign dma_req = pending &  ctrl_q.dma_route;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata = REG_W'(ctrl_q);
            ADDR_REF:  reg_rdata = REG_W'(ref_q);
            ADDR_CAP:  reg_rdata = REG_W'(capture);
            ADDR_CNT:  reg_rdata = REG_W'(count);
            ADDR_EVT:  reg_rdata = REG_W'({ref_flag, cap_flag});
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ctm_checker.sv
`timescale 1ns/1ps
module ctm_checker
    import ctm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              irq,
    input logic              dma_req,
    input logic              tmr_out,
    input logic [CNT_W-1:0]  count,
    input logic              en,
    input logic              restart,
    input logic              toggle,
    input logic              match,
    input logic              cap_hit,
    input logic              cap_flag,
    input logic              ref_flag
);
    logic cnt_write;
    assign cnt_write = reg_wr && (reg_addr == ADDR_CNT);

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({irq, dma_req})); // R10
    AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst) (irq || dma_req) |-> (cap_flag || ref_flag)); // R10
    AST_CNT_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst) cnt_write |=> (count == '0)); // R2
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst) (!en && !cnt_write) |=> $stable(count)); // R4
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst) (match && restart) |=> (count == '0)); // R7
    AST_FREERUN_STEP: assert property (@(posedge clk) disable iff (rst) (match && !restart) |=> (count == $past(count) + 1'b1)); // R7
    AST_REF_FLAG_SET: assert property (@(posedge clk) disable iff (rst) match |=> ref_flag); // R7
    AST_CAP_FLAG_SET: assert property (@(posedge clk) disable iff (rst) cap_hit |=> cap_flag); // R6
    AST_PULSE_LOW: assert property (@(posedge clk) disable iff (rst) (match && !toggle) |=> !tmr_out); // R8
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst) (match && toggle) |=> (tmr_out != $past(tmr_out))); // R9
endmodule

bind capcmp_timer ctm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .irq      (irq),
    .dma_req  (dma_req),
    .tmr_out  (tmr_out),
    .count    (count),
    .en       (ctrl_q.enable),
    .restart  (ctrl_q.restart),
    .toggle   (ctrl_q.toggle),
    .match    (match),
    .cap_hit  (cap_hit),
    .cap_flag (cap_flag),
    .ref_flag (ref_flag)
);

// File: tb/capcmp_timer_bench.sv
`timescale 1ns/1ps
module capcmp_timer_bench;
    import ctm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        dma_ack = 1'b0;
    logic        tmr_in = 1'b0;
    logic        tmr_out, irq, dma_req;

    int checks = 0;
    int errors = 0;
    int j = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    capcmp_timer u_capcmp_timer (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_ack(dma_ack),
        .tmr_in(tmr_in), .tmr_out(tmr_out), .irq(irq), .dma_req(dma_req)
    );

    function automatic logic [31:0] mk_ctrl(bit en, bit [1:0] src, bit rs, bit rq,
                                            bit tg, bit [1:0] edg, bit [7:0] dv, bit dm);
        return {15'd0, dm, dv, edg, tg, rq, rs, src, en};
    endfunction

    function automatic int exp_div_count(int cycles, int base, int dv);
        return cycles / (base * (dv + 1));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
        j += n;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        j += 2;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic setup(logic [31:0] refv, logic [31:0] ctrl);
        wr(3'd0, 32'd0);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd3);
        wr(3'd1, refv);
        wr(3'd0, ctrl);
        j = 0;
    endtask

    task automatic pin_pulses(int n);
        for (int i = 0; i < n; i++) begin
            tmr_in = 1'b1; step(4);
            tmr_in = 1'b0; step(4);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        prev;
        void'($urandom(32'h5eed_71e3));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            chk("R1 reset register", v, 32'd0);
        end
        chk("R1 reset out", {31'd0, tmr_out}, 32'd1);
        chk("R1 reset requests", {30'd0, irq, dma_req}, 32'd0);

        // R4 bus clock divider, random and directed
        for (int t = 0; t < 4; t++) begin
            int dv = $urandom_range(0, 5);
            int k  = $urandom_range(10, 60);
            setup(32'hFFFF_FFFF, mk_ctrl(1, 2'd1, 0, 0, 0, 2'd0, dv[7:0], 0));
            step(k);
            rd(3'd3, v);
            chk("R4 bus divider count", v, exp_div_count(k, 1, dv));
        end
        setup(32'hFFFF_FFFF, mk_ctrl(1, 2'd1, 0, 0, 0, 2'd0, 8'd255, 0));
        step(255);
        rd(3'd3, v);
        chk("R4 first count after full period", v, 32'd0);
        step(345);
        rd(3'd3, v);
        chk("R4 divide by 256", v, exp_div_count(600, 1, 255));

        // R3 bus clock / 16
        for (int t = 0; t < 3; t++) begin
            int dv = $urandom_range(0, 2);
            int k  = $urandom_range(40, 150);
            setup(32'hFFFF_FFFF, mk_ctrl(1, 2'd2, 0, 0, 0, 2'd0, dv[7:0], 0));
            step(k);
            rd(3'd3, v);
            chk("R3 bus/16 count", v, exp_div_count(k, 16, dv));
        end

        // R3 no source selected
        setup(32'hFFFF_FFFF, mk_ctrl(1, 2'd0, 0, 0, 0, 2'd0, 8'd0, 0));
        step(20);
        rd(3'd3, v);
        chk("R3 source off holds", v, 32'd0);

        // R2 reads do not disturb, write clears
        setup(32'hFFFF_FFFF, mk_ctrl(1, 2'd1, 0, 0, 0, 2'd0, 8'd0, 0));
        for (int i = 0; i < 10; i++) begin
            rd(3'd3, v);
            step(1);
        end
        rd(3'd3, v);
        chk("R2 reads leave count", v, 32'd10);
        wr(3'd3, 32'hDEAD_BEEF);
        rd(3'd3, v);
        chk("R2 write clears counter", v, 32'd0);
        step(5);
        rd(3'd3, v);
        chk("R2 count after clear", v, 32'd5);

        // R7 restart on match
        begin
            int r = $urandom_range(3, 8);
            int k = $urandom_range(20, 40);
            setup(r, mk_ctrl(1, 2'd1, 1, 0, 0, 2'd0, 8'd0, 0));
            step(k);
            rd(3'd3, v);
            chk("R7 restart count", v, k % (r + 1));
            rd(3'd4, v);
            chk("R7 reference flag", v, 32'd2);
        end

        // R7 free run; R10 reference flag without request enable
        setup(32'd6, mk_ctrl(1, 2'd1, 0, 0, 0, 2'd0, 8'd0, 0));
        step(15);
        rd(3'd3, v);
        chk("R7 free run continues", v, 32'd15);
        rd(3'd4, v);
        chk("R7 free run flag", v, 32'd2);
        chk("R10 no request without enable", {30'd0, irq, dma_req}, 32'd0);

        // R8 pulse low for one divided period
        setup(32'd2, mk_ctrl(1, 2'd1, 1, 0, 0, 2'd0, 8'd1, 0));
        step(5);
        chk("R8 high before match", {31'd0, tmr_out}, 32'd1);
        step(1);
        chk("R8 low at match", {31'd0, tmr_out}, 32'd0);
        step(1);
        chk("R8 still low", {31'd0, tmr_out}, 32'd0);
        step(1);
        chk("R8 high after next tick", {31'd0, tmr_out}, 32'd1);

        // R9 toggle
        setup(32'd2, mk_ctrl(1, 2'd1, 1, 0, 1, 2'd0, 8'd0, 0));
        prev = tmr_out;
        step(3);
        chk("R9 first toggle", {31'd0, tmr_out}, {31'd0, ~prev});
        step(3);
        chk("R9 second toggle", {31'd0, tmr_out}, {31'd0, prev});

        // R5 R6 rising edge capture
        setup(32'hFFFF_FFFF, mk_ctrl(1, 2'd1, 0, 0, 0, 2'd1, 8'd0, 0));
        step(4);
        tmr_in = 1'b1;
        v = j + 2;
        step(3);
        begin
            logic [31:0] c;
            rd(3'd2, c);
            chk("R5 capture latency value", c, v);
        end
        rd(3'd4, v);
        chk("R6 capture flag", v, 32'd1);
        chk("R10 capture interrupt", {30'd0, irq, dma_req}, 32'd2);
        tmr_in = 1'b0;
        step(4);
        rd(3'd2, v);
        chk("R6 falling edge ignored in rise mode", v, 32'd6);

        // R6 falling edge mode
        setup(32'hFFFF_FFFF, mk_ctrl(1, 2'd1, 0, 0, 0, 2'd2, 8'd0, 0));
        step(3);
        tmr_in = 1'b1;
        step(4);
        rd(3'd4, v);
        chk("R6 rise ignored in fall mode", v, 32'd0);
        tmr_in = 1'b0;
        v = j + 2;
        step(3);
        begin
            logic [31:0] c;
            rd(3'd2, c);
            chk("R6 falling capture", c, v);
        end

        // R6 disabled capture
        setup(32'hFFFF_FFFF, mk_ctrl(1, 2'd1, 0, 0, 0, 2'd0, 8'd0, 0));
        pin_pulses(1);
        rd(3'd4, v);
        chk("R6 capture off", v, 32'd0);

        // R6 both edges, R11 single-bit clear
        setup(32'hFFFF_FFFF, mk_ctrl(1, 2'd1, 0, 0, 0, 2'd3, 8'd0, 0));
        step(2);
        tmr_in = 1'b1;
        step(3);
        rd(3'd2, v);
        chk("R6 both edges rise", v, 32'd4);
        wr(3'd4, 32'd1);
        rd(3'd4, v);
        chk("R11 write one clears capture flag", v, 32'd0);
        tmr_in = 1'b0;
        v = j + 2;
        step(3);
        begin
            logic [31:0] c;
            rd(3'd2, c);
            chk("R6 both edges fall", c, v);
        end

        // R3 external pin source
        setup(32'hFFFF_FFFF, mk_ctrl(1, 2'd3, 0, 0, 0, 2'd0, 8'd0, 0));
        pin_pulses(7);
        rd(3'd3, v);
        chk("R3 pin source count", v, 32'd7);
        setup(32'hFFFF_FFFF, mk_ctrl(1, 2'd3, 0, 0, 0, 2'd0, 8'd1, 0));
        pin_pulses(5);
        rd(3'd3, v);
        chk("R4 pin source divided", v, 32'd2);

        // R12 capture coincides with match
        begin
            logic [31:0] m = mk_ctrl(1, 2'd1, 1, 1, 0, 2'd1, 8'd0, 0);
            setup(32'd10, m);
            step(8);
            tmr_in = 1'b1;
            step(3);
            rd(3'd2, v);
            chk("R12 capture equals reference", v, 32'd10);
            rd(3'd4, v);
            chk("R12 both flags", v, 32'd3);
            rd(3'd3, v);
            chk("R12 counter restarted", v, 32'd0);
            chk("R12 interrupt", {30'd0, irq, dma_req}, 32'd2);
            tmr_in = 1'b0;
            wr(3'd0, m & ~32'd1);
            wr(3'd0, (m & ~32'd1) | 32'h0001_0000);
            chk("R10 routed to DMA", {30'd0, irq, dma_req}, 32'd1);
            wr(3'd4, 32'd1);
            rd(3'd4, v);
            chk("R11 clears only capture flag", v, 32'd2);
            chk("R10 reference request on DMA", {30'd0, irq, dma_req}, 32'd1);
            dma_ack = 1'b1;
            step(1);
            dma_ack = 1'b0;
            rd(3'd4, v);
            chk("R11 acknowledge clears flags", v, 32'd0);
            chk("R11 request dropped", {30'd0, irq, dma_req}, 32'd0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule